// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the lookup front end of a cache whose set is chosen from the virtual address while the stored tag names a physical line. In the cycle a request is accepted, two reads run side by side. One picks the cache line at the virtual index. The other searches a small fully associative translation buffer for the page number. The registered results of both meet in the next cycle. There the physical page from the translation, joined with the in-page part of the line address, is compared against the stored tag. Hit, miss and data appear one cycle after acceptance. If the translation is absent, the block raises a translation-miss output and holds the request. It retries the translation every cycle until a refill supplies the page.

The stored tag covers every physical address bit above the line offset, including the bits that also feed the index. So two cached copies of one physical line always carry the same tag. When the virtual index is wider than the page offset, the same physical line could sit in several sets. These sets differ only in the index bits above the page offset. The fill port compares the incoming physical tag against all of those sibling sets in the fill cycle. It invalidates a matching copy before installing the new line, so at most one copy is ever held. The translation buffer is refilled through its own port. An existing page number is rewritten in place; a new one takes the round-robin slot.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, the outputs `resp_hit`, `resp_miss`, `resp_tlb_miss` and `fill_alias` are 0, and every translation entry and cache line is invalid.
- R2: Consider a request accepted in cycle c (`req_valid` and `req_ready` both 1). If its page is translated and the line at its index is valid with tag {physical page, in-page line bits}, then `resp_hit` is 1 in cycle c+1 and `resp_data` carries the data of the last fill of that line.
- R3: A translated request whose indexed line is invalid, or holds a different tag, gives `resp_miss` = 1 and `resp_hit` = 0 in cycle c+1.
- R4: The set index is the low `IDX_W` bits of the virtual line address `req_vline`. Two virtual pages that map to the same physical page and share those index bits hit the same line.
- R5: A request whose page is not translated gives `resp_tlb_miss` = 1 in cycle c+1. From then on `req_ready` stays 0 and the request is held. Hit or miss is not reported before a refill for that page arrives. The held request then resolves in the second cycle after the refill cycle.
- R6: The translation buffer holds 4 entries. A refill of a page number not yet present writes the slot named by a round-robin pointer (0,1,2,3,0...), evicting that slot's previous page.
- R7: A refill of a page number already present rewrites that entry's physical page and leaves the round-robin pointer unchanged; no page ever matches two entries.
- R8: A fill whose physical tag already sits in a sibling set (same index except for the index bits above the page offset) raises `fill_alias` in the fill cycle and invalidates that sibling copy, so a later lookup through the sibling index misses.
- R9: A fill with no matching sibling leaves `fill_alias` at 0 and changes only the line at `fill_index`.
- R10: While `fill_valid` is 1, `req_ready` is 0 and an offered request is not accepted, producing no response in the next cycle.
- R11: The tag compare includes the physical page bits that overlap the virtual index. A lookup whose physical page differs from the stored one only in its lowest bit misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request offered |
| req_vline | input | VA_W-OFF_W | Virtual line address (virtual address without line offset) |
| req_ready | output | 1 | Request accepted this cycle when high |
| resp_hit | output | 1 | Accepted request hit |
| resp_miss | output | 1 | Accepted request missed in the cache |
| resp_tlb_miss | output | 1 | Held request is waiting for a translation |
| resp_data | output | DATA_W | Line data on a hit, zero otherwise |
| tlb_wr_valid | input | 1 | Translation refill strobe |
| tlb_wr_vpn | input | VA_W-PAGE_W | Virtual page number to install |
| tlb_wr_ppn | input | PA_W-PAGE_W | Physical page number to install |
| fill_valid | input | 1 | Line fill strobe |
| fill_index | input | IDX_W | Virtual set index receiving the line |
| fill_pline | input | PA_W-OFF_W | Physical line address, stored as the tag |
| fill_data | input | DATA_W | Line data |
| fill_alias | output | 1 | A sibling copy of the filled line was found and dropped |

## Verification
The bench fills every set from two differently coloured pages, then reads them back through synonyms of the same colour and of the other colour. A design indexing from physical bits, or comparing a tag short of the overlapping bit, would hit where a miss is due. All 128 lines are then refilled through the opposite colour. A missing alias check would leave stale twins that still hit through the old index and would never raise the alias flag. Held translation misses are refilled and watched cycle by cycle, so a design that resolves too early, drops the held request, or consumes a round-robin slot on an in-place update shows a wrong eviction or a premature hit.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

   // Number of virtual index bits that reach above the page offset.
   function automatic int alias_bits(int off_w, int idx_w, int page_w);
      int d;
      d = off_w + idx_w - page_w;
      return (d > 0) ? d : 0;
   endfunction

   // Outcome of a lookup, used for readability inside the top.
   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_HIT  = 2'd1,
      LK_MISS = 2'd2,
      LK_XLAT = 2'd3
   } lk_kind_e;

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
   parameter int VPN_W = 12,
   parameter int PPN_W = 8,
   parameter int TLB_N = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PPN_W-1:0] wr_ppn
);
   localparam int RR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

   initial begin : p_cfg_chk
      assert (TLB_N >= 2 && (1 << RR_W) == TLB_N)
         else $error("TLB_N must be a power of two of at least 2");
   end

   logic [TLB_N-1:0] vld_q;
   logic [VPN_W-1:0] vpn_q [TLB_N];
   logic [PPN_W-1:0] ppn_q [TLB_N];
   logic [RR_W-1:0]  rr_q;

   logic [TLB_N-1:0] lk_match;
   logic [TLB_N-1:0] wr_match;
   logic             wr_update;
   logic [RR_W-1:0]  wr_slot;

   for (genvar e = 0; e < TLB_N; e++) begin : g_ent
      assign lk_match[e] = vld_q[e] && (vpn_q[e] == lk_vpn);
      assign wr_match[e] = vld_q[e] && (vpn_q[e] == wr_vpn);
   end

   assign lk_hit    = |lk_match;
   assign wr_update = |wr_match;

   always_comb begin
      lk_ppn = '0;
      for (int e = 0; e < TLB_N; e++) begin
         if (lk_match[e]) lk_ppn = lk_ppn | ppn_q[e];
      end
   end

   always_comb begin
      wr_slot = rr_q;
      for (int e = 0; e < TLB_N; e++) begin
         if (wr_match[e]) wr_slot = RR_W'(e);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         rr_q  <= '0;
         for (int e = 0; e < TLB_N; e++) begin
            vpn_q[e] <= '0;
            ppn_q[e] <= '0;
         end
      end else if (wr_en) begin
         vld_q[wr_slot] <= 1'b1;
         vpn_q[wr_slot] <= wr_vpn;
         ppn_q[wr_slot] <= wr_ppn;
         if (!wr_update) rr_q <= rr_q + 1'b1;
      end
   end

   // R7: in-place rewrites keep a single entry per page
   assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   // R7: an in-place rewrite does not advance the pointer
   assert_rr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_update) |=> (rr_q == $past(rr_q)));

   // R6: a new page advances the pointer by one
   assert_rr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_update) |=> (rr_q == $past(rr_q) + 1'b1));

endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
   parameter int IDX_W   = 8,
   parameter int TAG_W   = 15,
   parameter int DATA_W  = 32,
   parameter int ALIAS_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_vld,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   output logic              alias_found
);
   localparam int LINES = 1 << IDX_W;
   localparam int NCOL  = 1 << ALIAS_W;
   localparam int LOW_W = IDX_W - ALIAS_W;

   initial begin : p_cfg_chk
      assert (LOW_W >= 1 && ALIAS_W <= 4)
         else $error("alias colour count out of range");
   end

   logic [LINES-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   logic [IDX_W-1:0]  col_idx [NCOL];
   logic [NCOL-1:0]   alias_vec;
   logic [IDX_W-1:0]  alias_pick;

   assign rd_vld  = vld_q[rd_idx];
   assign rd_tag  = tag_q[rd_idx];
   assign rd_data = data_q[rd_idx];

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      if (ALIAS_W > 0) begin : g_sib
         assign col_idx[c]   = {ALIAS_W'(c), fill_idx[LOW_W-1:0]};
         assign alias_vec[c] = (ALIAS_W'(c) != fill_idx[IDX_W-1 -: ALIAS_W])
                               && vld_q[col_idx[c]]
                               && (tag_q[col_idx[c]] == fill_tag);
      end else begin : g_nosib
         assign col_idx[c]   = fill_idx;
         assign alias_vec[c] = 1'b0;
      end
   end

   assign alias_found = |alias_vec;

   always_comb begin
      alias_pick = fill_idx;
      for (int c = 0; c < NCOL; c++) begin
         if (alias_vec[c]) alias_pick = col_idx[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (fill_en) begin
         for (int c = 0; c < NCOL; c++) begin
            if (alias_vec[c]) vld_q[col_idx[c]] <= 1'b0;
         end
         vld_q[fill_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[fill_idx]  <= fill_tag;
         data_q[fill_idx] <= fill_data;
      end
   end

   // R8: invalidation keeps at most one sibling copy
   assert_one_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> $onehot0(alias_vec));

   // R8: a detected sibling is gone after the fill
   assert_alias_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && alias_found) |=> !vld_q[$past(alias_pick)]);

   // R9: the target line holds the new tag after a fill
   assert_fill_installed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (vld_q[$past(fill_idx)] && (tag_q[$past(fill_idx)] == $past(fill_tag))));

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
   parameter int VA_W   = 24,
   parameter int PA_W   = 20,
   parameter int PAGE_W = 12,
   parameter int OFF_W  = 5,
   parameter int IDX_W  = 8,
   parameter int DATA_W = 32,
   parameter int TLB_N  = 4,
   localparam int VLINE_W = VA_W - OFF_W,
   localparam int VPN_W   = VA_W - PAGE_W,
   localparam int PPN_W   = PA_W - PAGE_W,
   localparam int TAG_W   = PA_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VLINE_W-1:0] req_vline,
   output logic               req_ready,
   output logic               resp_hit,
   output logic               resp_miss,
   output logic               resp_tlb_miss,
   output logic [DATA_W-1:0]  resp_data,
   input  logic               tlb_wr_valid,
   input  logic [VPN_W-1:0]   tlb_wr_vpn,
   input  logic [PPN_W-1:0]   tlb_wr_ppn,
   input  logic               fill_valid,
   input  logic [IDX_W-1:0]   fill_index,
   input  logic [TAG_W-1:0]   fill_pline,
   input  logic [DATA_W-1:0]  fill_data,
   output logic               fill_alias
);
   import vipt_pkg::*;

   localparam int ALIAS_W = alias_bits(OFF_W, IDX_W, PAGE_W);
   localparam int INPG_W  = PAGE_W - OFF_W;

   initial begin : p_cfg_chk
      assert (PAGE_W > OFF_W && VA_W > PAGE_W && PA_W > PAGE_W)
         else $error("address split inconsistent");
      assert (OFF_W + IDX_W <= VA_W)
         else $error("index does not fit the virtual address");
   end

   // stage-1 registers: results of the parallel reads
   logic               s1_valid;
   logic [VLINE_W-1:0] s1_vline;
   logic               s1_xlat_ok;
   logic [PPN_W-1:0]   s1_ppn;
   logic               s1_line_vld;
   logic [TAG_W-1:0]   s1_line_tag;
   logic [DATA_W-1:0]  s1_data;
   logic               s1_stale;

   logic               hold;
   logic               capture;
   logic [VLINE_W-1:0] look_vline;
   logic               tlb_hit;
   logic [PPN_W-1:0]   tlb_ppn;
   logic               rd_vld;
   logic [TAG_W-1:0]   rd_tag;
   logic [DATA_W-1:0]  rd_data;
   logic [TAG_W-1:0]   phys_tag;
   logic               tag_ok;
   lk_kind_e           kind;

   assign hold       = s1_valid && (!s1_xlat_ok || s1_stale);
   assign req_ready  = !hold && !fill_valid;
   assign capture    = hold || (req_valid && req_ready);
   assign look_vline = hold ? s1_vline : req_vline;

   vipt_tlb #(
      .VPN_W (VPN_W),
      .PPN_W (PPN_W),
      .TLB_N (TLB_N)
   ) tlb_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lk_vpn (look_vline[VLINE_W-1:INPG_W]),
      .lk_hit (tlb_hit),
      .lk_ppn (tlb_ppn),
      .wr_en  (tlb_wr_valid),
      .wr_vpn (tlb_wr_vpn),
      .wr_ppn (tlb_wr_ppn)
   );

   vipt_line_store #(
      .IDX_W   (IDX_W),
      .TAG_W   (TAG_W),
      .DATA_W  (DATA_W),
      .ALIAS_W (ALIAS_W)
   ) store_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_idx      (look_vline[IDX_W-1:0]),
      .rd_vld      (rd_vld),
      .rd_tag      (rd_tag),
      .rd_data     (rd_data),
      .fill_en     (fill_valid),
      .fill_idx    (fill_index),
      .fill_tag    (fill_pline),
      .fill_data   (fill_data),
      .alias_found (fill_alias)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid    <= 1'b0;
         s1_vline    <= '0;
         s1_xlat_ok  <= 1'b0;
         s1_ppn      <= '0;
         s1_line_vld <= 1'b0;
         s1_line_tag <= '0;
         s1_data     <= '0;
         s1_stale    <= 1'b0;
      end else begin
         s1_valid <= capture;
         if (capture) begin
            s1_vline    <= look_vline;
            s1_xlat_ok  <= tlb_hit;
            s1_ppn      <= tlb_ppn;
            s1_line_vld <= rd_vld;
            s1_line_tag <= rd_tag;
            s1_data     <= rd_data;
            s1_stale    <= fill_valid;
         end
      end
   end

   // physical tag: translated page joined with the in-page line bits
   assign phys_tag = {s1_ppn, s1_vline[INPG_W-1:0]};
   assign tag_ok   = s1_line_vld && (s1_line_tag == phys_tag);

   always_comb begin
      if (!s1_valid)                    kind = LK_IDLE;
      else if (!s1_xlat_ok)             kind = LK_XLAT;
      else if (s1_stale)                kind = LK_IDLE;
      else if (tag_ok)                  kind = LK_HIT;
      else                              kind = LK_MISS;
   end

   assign resp_hit      = (kind == LK_HIT);
   assign resp_miss     = (kind == LK_MISS);
   assign resp_tlb_miss = (kind == LK_XLAT);
   assign resp_data     = resp_hit ? s1_data : '0;

   // R2: every accepted request produces an outcome the next cycle
   assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (resp_hit || resp_miss || resp_tlb_miss));

   // R5: at most one outcome, and a pending translation blocks new requests
   assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({resp_hit, resp_miss, resp_tlb_miss}));
   assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      resp_tlb_miss |-> !req_ready);
   assert_hold_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_xlat_ok) |=> (s1_valid && $stable(s1_vline)));

   // R10: fills take the arrays
   assert_fill_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> !req_ready);

endmodule

// File: tb/vipt_lookup_tb.sv
module vipt_lookup_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [18:0] req_vline = '0;
   logic        req_ready;
   logic        resp_hit, resp_miss, resp_tlb_miss;
   logic [31:0] resp_data;
   logic        tlb_wr_valid = 1'b0;
   logic [11:0] tlb_wr_vpn = '0;
   logic [7:0]  tlb_wr_ppn = '0;
   logic        fill_valid = 1'b0;
   logic [7:0]  fill_index = '0;
   logic [14:0] fill_pline = '0;
   logic [31:0] fill_data = '0;
   logic        fill_alias;

   int total = 0;
   int bad = 0;
   int gen = 0;

   // reference state
   bit          m_vld [256];
   int          m_tag [256];
   logic [31:0] m_dat [256];
   bit          t_vld [4];
   int          t_vpn [4];
   int          t_ppn [4];
   int          t_rr = 0;

   always #5 clk = ~clk;

   vipt_lookup dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vline(req_vline), .req_ready(req_ready),
      .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_tlb_miss(resp_tlb_miss),
      .resp_data(resp_data),
      .tlb_wr_valid(tlb_wr_valid), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn),
      .fill_valid(fill_valid), .fill_index(fill_index), .fill_pline(fill_pline),
      .fill_data(fill_data), .fill_alias(fill_alias)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
      end
   endtask

   function automatic int t_find(input int vpn);
      for (int e = 0; e < 4; e++) if (t_vld[e] && t_vpn[e] == vpn) return e;
      return -1;
   endfunction

   task automatic do_tlb(input int vpn, input int ppn);
      int e;
      @(negedge clk);
      tlb_wr_valid = 1'b1; tlb_wr_vpn = 12'(vpn); tlb_wr_ppn = 8'(ppn);
      @(negedge clk);
      tlb_wr_valid = 1'b0;
      e = t_find(vpn);
      if (e < 0) begin
         e = t_rr;
         t_rr = (t_rr + 1) % 4;
      end
      t_vld[e] = 1'b1; t_vpn[e] = vpn; t_ppn[e] = ppn;
   endtask

   // fill the line seen through virtual page vpn, in-page line low, from physical page ppn
   task automatic do_fill(input int vpn, input int ppn, input int low, input string rq);
      int idx, tg, sib;
      bit exp_alias;
      logic [31:0] d;
      idx = ((vpn & 1) << 7) | low;
      tg  = (ppn << 7) | low;
      sib = idx ^ 128;
      gen++;
      d = 32'h5A00_0000 ^ (32'(tg) << 4) ^ 32'(gen);
      exp_alias = m_vld[sib] && (m_tag[sib] == tg);
      @(negedge clk);
      fill_valid = 1'b1; fill_index = 8'(idx); fill_pline = 15'(tg); fill_data = d;
      #1;
      check(fill_alias == exp_alias, rq, "fill_alias", fill_alias, exp_alias);
      @(negedge clk);
      fill_valid = 1'b0;
      if (exp_alias) m_vld[sib] = 1'b0;
      m_vld[idx] = 1'b1; m_tag[idx] = tg; m_dat[idx] = d;
   endtask

   task automatic expect_outcome(input int vpn, input int low, input string rq);
      int e, idx;
      bit exp_hit;
      e = t_find(vpn);
      idx = ((vpn & 1) << 7) | low;
      exp_hit = m_vld[idx] && (m_tag[idx] == ((t_ppn[e] << 7) | low));
      check(resp_hit == exp_hit && resp_miss == !exp_hit && !resp_tlb_miss,
            rq, "hit/miss", {resp_hit, resp_miss, resp_tlb_miss}, {exp_hit, !exp_hit, 1'b0});
      if (exp_hit)
         check(resp_data == m_dat[idx], rq, "data", resp_data, m_dat[idx]);
   endtask

   // one request; if its page is untranslated, leaves the block holding it
   task automatic do_look(input int vpn, input int low, input string rq);
      @(negedge clk);
      req_valid = 1'b1; req_vline = 19'((vpn << 7) | low);
      #1;
      check(req_ready == 1'b1, rq, "ready before accept", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      if (t_find(vpn) < 0)
         check(resp_tlb_miss && !resp_hit && !resp_miss, rq, "tlb_miss",
               {resp_hit, resp_miss, resp_tlb_miss}, 3'b001);
      else
         expect_outcome(vpn, low, rq);
   endtask

   // hold a missed translation, refill it, watch it resolve
   task automatic xlat_miss(input int vpn, input int ppn, input int low, input string rq);
      do_look(vpn, low, rq);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(resp_tlb_miss && !req_ready && !resp_hit && !resp_miss, "R5",
               "held", {resp_tlb_miss, req_ready}, 2'b10);
      end
      do_tlb(vpn, ppn);
      check(resp_tlb_miss && !resp_hit && !resp_miss, "R5", "no early resolve",
            {resp_hit, resp_miss, resp_tlb_miss}, 3'b001);
      @(negedge clk);
      expect_outcome(vpn, low, "R5");
      @(negedge clk);
      check(req_ready && !resp_hit && !resp_miss && !resp_tlb_miss, "R5", "released",
            {req_ready, resp_hit, resp_miss, resp_tlb_miss}, 4'b1000);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < 256; i++) m_vld[i] = 1'b0;
      for (int e = 0; e < 4; e++) t_vld[e] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(req_ready && !resp_hit && !resp_miss && !resp_tlb_miss && !fill_alias, "R1",
            "reset state", {req_ready, resp_hit, resp_miss, resp_tlb_miss, fill_alias}, 5'b10000);
      xlat_miss(0, 8'h10, 9, "R1");

      do_tlb(1, 8'h21);
      do_tlb(2, 8'h10);
      do_tlb(3, 8'h10);
      for (int l = 0; l < 8; l++) do_look(0, l, "R3");   // cold: all miss

      // fill every set from two pages of different colours
      for (int l = 0; l < 128; l++) do_fill(0, 8'h10, l, "R9");
      for (int l = 0; l < 128; l++) do_fill(1, 8'h21, l, "R9");
      for (int l = 0; l < 128; l++) do_look(0, l, "R2");
      for (int l = 0; l < 128; l++) do_look(1, l, "R2");
      for (int l = 0; l < 128; l++) do_look(2, l, "R4");  // synonym, same colour
      for (int l = 0; l < 128; l++) do_look(3, l, "R3");  // synonym, other colour

      // refill through the other colour: each finds and drops its twin
      for (int l = 0; l < 128; l++) do_fill(3, 8'h10, l, "R8");
      for (int l = 0; l < 128; l += 3) do_look(0, l, "R8");
      for (int l = 0; l < 128; l += 3) do_look(3, l, "R8");
      for (int l = 0; l < 128; l += 5) do_look(1, l, "R8");
      for (int l = 0; l < 128; l += 2) do_fill(0, 8'h10, l, "R8");
      for (int l = 0; l < 128; l += 7) do_look(3, l, "R8");

      // R10: request offered during a fill is ignored
      @(negedge clk);
      fill_valid = 1'b1; fill_index = 8'd77; fill_pline = 15'((8'h44 << 7) | 77);
      fill_data = 32'hC0DE_0077;
      req_valid = 1'b1; req_vline = 19'(77);
      #1;
      check(req_ready == 1'b0, "R10", "ready during fill", req_ready, 0);
      @(negedge clk);
      fill_valid = 1'b0; req_valid = 1'b0;
      m_vld[77] = 1'b1; m_tag[77] = (8'h44 << 7) | 77; m_dat[77] = 32'hC0DE_0077;
      check(!resp_hit && !resp_miss && !resp_tlb_miss, "R10", "no response",
            {resp_hit, resp_miss, resp_tlb_miss}, 0);

      // R5/R6: untranslated page held, round-robin eviction
      xlat_miss(5, 8'h21, 3, "R5");
      do_look(0, 4, "R6");
      if (t_find(0) < 0) begin
         for (int k = 0; k < 2; k++) @(negedge clk);
         do_tlb(0, 8'h10);
         @(negedge clk);
         expect_outcome(0, 4, "R6");
         @(negedge clk);
      end
      do_look(1, 6, "R6");
      if (t_find(1) < 0) begin
         do_tlb(1, 8'h21);
         @(negedge clk);
         expect_outcome(1, 6, "R6");
         @(negedge clk);
      end

      // R7: in-place rewrite; R11: page differing in the overlapping bit
      do_tlb(3, 8'h11);
      for (int l = 0; l < 128; l += 9) do_look(3, l, "R7");
      xlat_miss(6, 8'h11, 2, "R11");
      for (int l = 0; l < 128; l += 4) do_look(6, l, "R11");
      do_look(5, 3, "R7");
      do_look(3, 8, "R7");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule